// File: doc/BRIEF.md
# Boot Calibration Loader Sequencer

This block runs between reset release and the first instruction fetch of a small processor. It reads a fixed-length block of calibration bytes from a nonvolatile memory port, one byte per read handshake, and places a copy of each byte in a scratch window of the processor's RAM. While it copies, it keeps a 16-bit running checksum. The first `CAL_LEN-2` bytes are calibration values. The last two bytes form a little-endian check word.

When the biased checksum comes out at zero, the block loads the calibration register bank and clears the processor RAM, leaving out the protected cells. It then writes a return code and releases the processor. The release tells the core to zero its stack pointer, program counter, index, flags and accumulator, and to fetch from address 0000h. When the checksum is nonzero, the block increments a persistent fail counter held in RAM and asks the reset controller for an internal reset. That reset re-enters the sequence without losing the count. A preserve flag, which only a watchdog reset leaves set, keeps a user window of RAM intact across the clear.

The states are IDLE, INIT, FETCH, CHECK, FAIL, APPLY, CLEAR, RCODE and DONE. Any reset event moves the machine from any state to INIT. A supervisory call with a zero accumulator moves it from IDLE to INIT. The remaining transitions are:
- INIT goes to FETCH.
- FETCH goes to CHECK when the last byte is accepted.
- CHECK goes to APPLY when the checksum passes, or to FAIL when it does not.
- FAIL goes to IDLE.
- APPLY goes to CLEAR.
- CLEAR goes to RCODE after address FFh.
- RCODE goes to DONE.
- DONE goes to IDLE.

CLEAR visits every RAM address in ascending order, one per cycle.

Top module: `bootcal_seq`

## Requirements
- R1: A sequence starts on every `rst_event` pulse, in any state. It also starts on an `sv_call` pulse with `sv_acc` equal to 00h, but only while the block is idle. An `sv_call` with a nonzero `sv_acc` causes no RAM write and leaves `cpu_run` unchanged.
- R2: Nonvolatile reads use addresses `NV_BASE+i` for i = 0 to `CAL_LEN-1`, in ascending order. `nv_req` stays high with a stable address until `nv_vld` is seen, and each `nv_vld` cycle consumes exactly one byte.
- R3: Byte i is written to RAM address `SCR_BASE+i` in the cycle its `nv_vld` is high. The clear never overwrites that window.
- R4: The checksum starts at zero for each sequence. Bytes 0 to `CAL_LEN-3` are added as 8-bit values. Byte `CAL_LEN-2` is added as the low byte and byte `CAL_LEN-1` as the high byte of a 16-bit word. The sum is taken modulo 2^16. The check passes only if the sum plus 00EBh is 0000h modulo 2^16.
- R5: On a pass, `cal_regs` byte i (bits 8i+7:8i) takes calibration byte i, for i below `CAL_LEN-2`. On a fail, `cal_regs` keeps its previous value.
- R6: On a fail, `ires_req` pulses for exactly one cycle. The fail count at RAM FCh is incremented modulo 256 and rewritten. No return code is written, and `cpu_run` stays low.
- R7: `rst_cause` is encoded as 0 = power-on, 1 = external pin, 2 = watchdog, 3 = internal. A reset event with cause 0, 1 or 2 sets the fail count to 00h and writes it to FCh during INIT. Cause 3 and a supervisory call keep the count.
- R8: The preserve flag is written by `keep_we`/`keep_d`. It is cleared by any `rst_event` whose cause is not 2, and it is left unchanged by cause 2 and by supervisory calls.
- R9: After a pass, every RAM address from 00h to FFh is written with 00h, with these exceptions: F8h, FCh, the scratch window, and, while the preserve flag is set, the range `KEEP_LO` to `KEEP_HI`.
- R10: After the clear, RAM F8h is written with 00h when the sequence was entered by a reset event, or with 02h when it was entered by a supervisory call.
- R11: `boot_done` pulses for one cycle at the end of a passing sequence, and `cpu_run` goes high in the following cycle. `cpu_run` is low from power-up, and from each entry until that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low storage reset, asserted at first power-up only |
| rst_event | input | 1 | Pulse: a system reset has just been released |
| rst_cause | input | 2 | Cause of the reset event (0 power-on, 1 pin, 2 watchdog, 3 internal) |
| sv_call | input | 1 | Pulse: the processor issued a supervisory call |
| sv_acc | input | 8 | Accumulator value carried by the supervisory call |
| keep_we | input | 1 | Write strobe for the preserve flag |
| keep_d | input | 1 | New value of the preserve flag |
| nv_req | output | 1 | Nonvolatile read request, held until valid |
| nv_addr | output | NV_AW | Nonvolatile read address |
| nv_vld | input | 1 | Read data valid, one cycle per byte |
| nv_data | input | 8 | Read data |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| cal_regs | output | (CAL_LEN-2)*8 | Calibration register bank |
| ires_req | output | 1 | One-cycle request for an internal hardware reset |
| cpu_run | output | 1 | High when the processor may run from address 0000h |
| boot_done | output | 1 | One-cycle release pulse: zero the core registers and start fetching |

## Verification
A wrong running checksum or byte counter shows up within one sequence as the opposite verdict. The bench then sees an `ires_req` pulse where it expected `boot_done`, or the reverse, together with a stale or wrong `cal_regs`. A skip decode that is off shows in the RAM image after the roughly 256-cycle clear, as a lost fail count, return code, scratch byte or preserved byte. A wrong cause decode for the fail count or the preserve flag stays hidden until the next sequence. The sweep therefore chains runs, so that each run starts from the state the previous one left behind.

// File: rtl/bootcal_pkg.sv
package bootcal_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INIT,
        S_FETCH,
        S_CHECK,
        S_FAIL,
        S_APPLY,
        S_CLEAR,
        S_RCODE,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_WDR  = 2'd2,
        CAUSE_SELF = 2'd3
    } rst_cause_t;

    localparam logic [15:0] CSUM_BIAS = 16'h00EB;
    localparam logic [7:0]  RC_OK     = 8'h00;
    localparam logic [7:0]  RC_SOFT   = 8'h02;

endpackage

// File: rtl/bootcal_csum.sv
module bootcal_csum
    import bootcal_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add_en,
    input  logic       is_hi,
    input  logic [7:0] byte_in,
    output logic       pass
);

    logic [W-1:0] sum_q;
    logic [W-1:0] addend;

    always_comb begin
        addend = '0;
        if (is_hi) addend[15:8] = byte_in;
        else       addend[7:0]  = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr)    sum_q <= '0;
        else if (add_en) sum_q <= sum_q + addend;
    end

    assign pass = ((sum_q + W'(CSUM_BIAS)) == '0);

    // A freshly cleared sum cannot pass, because the bias is nonzero.
    p_clear_nopass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pass);

endmodule

// File: rtl/bootcal_walker.sv
module bootcal_walker #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (start) addr <= '0;
        else if (step)  addr <= addr + 1'b1;
    end

    assign last = &addr;

    p_start_step_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && step));

endmodule

// File: rtl/bootcal_seq.sv
module bootcal_seq
    import bootcal_pkg::*;
#(
    parameter int CAL_LEN  = 16,
    parameter int NV_AW    = 8,
    parameter int NV_BASE  = 'h00,
    parameter int RAM_AW   = 8,
    parameter int SCR_BASE = 'hE0,
    parameter int KEEP_LO  = 'hC0,
    parameter int KEEP_HI  = 'hDF,
    parameter int RC_ADDR  = 'hF8,
    parameter int FC_ADDR  = 'hFC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rst_event,
    input  logic [1:0]                rst_cause,
    input  logic                      sv_call,
    input  logic [7:0]                sv_acc,
    input  logic                      keep_we,
    input  logic                      keep_d,
    output logic                      nv_req,
    output logic [NV_AW-1:0]          nv_addr,
    input  logic                      nv_vld,
    input  logic [7:0]                nv_data,
    output logic                      ram_we,
    output logic [RAM_AW-1:0]         ram_addr,
    output logic [7:0]                ram_wdata,
    output logic [(CAL_LEN-2)*8-1:0]  cal_regs,
    output logic                      ires_req,
    output logic                      cpu_run,
    output logic                      boot_done
);

    localparam int CAL_N   = CAL_LEN - 2;
    localparam int IDXW    = $clog2(CAL_LEN);
    localparam int SCR_END = SCR_BASE + CAL_LEN;
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(CAL_LEN - 1);

    seq_state_t state, nxt;

    logic [IDXW-1:0]           idx;
    logic [7:0]                fail_cnt;
    logic                      keep_bit;
    logic                      soft_q;
    logic [CAL_N-1:0][7:0]     stage;
    logic [CAL_N*8-1:0]        cal_q;
    logic                      run_q;
    logic                      go_sv;
    logic                      csum_pass;
    logic [RAM_AW-1:0]         wlk_addr;
    logic                      wlk_last;
    logic                      skip;

    assign go_sv = sv_call && (sv_acc == 8'h00) && (state == S_IDLE) && !rst_event;

    bootcal_csum #(.W(16)) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_INIT),
        .add_en  ((state == S_FETCH) && nv_vld),
        .is_hi   (idx == IDX_LAST),
        .byte_in (nv_data),
        .pass    (csum_pass)
    );

    bootcal_walker #(.AW(RAM_AW)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == S_APPLY),
        .step  (state == S_CLEAR),
        .addr  (wlk_addr),
        .last  (wlk_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (rst_event) begin
            nxt = S_INIT;
        end else begin
            unique case (state)
                S_IDLE:  if (go_sv) nxt = S_INIT;
                S_INIT:  nxt = S_FETCH;
                S_FETCH: if (nv_vld && idx == IDX_LAST) nxt = S_CHECK;
                S_CHECK: nxt = csum_pass ? S_APPLY : S_FAIL;
                S_FAIL:  nxt = S_IDLE;
                S_APPLY: nxt = S_CLEAR;
                S_CLEAR: if (wlk_last) nxt = S_RCODE;
                S_RCODE: nxt = S_DONE;
                S_DONE:  nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            fail_cnt <= '0;
            keep_bit <= 1'b0;
            soft_q   <= 1'b0;
            stage    <= '0;
            cal_q    <= '0;
            run_q    <= 1'b0;
        end else begin
            if (keep_we) keep_bit <= keep_d;
            if (rst_event) begin
                idx    <= '0;
                soft_q <= 1'b0;
                run_q  <= 1'b0;
                if (rst_cause != CAUSE_SELF) fail_cnt <= '0;
                if (rst_cause != CAUSE_WDR)  keep_bit <= 1'b0;
            end else if (go_sv) begin
                idx    <= '0;
                soft_q <= 1'b1;
                run_q  <= 1'b0;
            end else begin
                if (state == S_FETCH && nv_vld) begin
                    for (int i = 0; i < CAL_N; i++)
                        if (int'(idx) == i) stage[i] <= nv_data;
                    idx <= idx + 1'b1;
                end
                if (state == S_FAIL)  fail_cnt <= fail_cnt + 8'd1;
                if (state == S_APPLY) cal_q    <= stage;
                if (state == S_DONE)  run_q    <= 1'b1;
            end
        end
    end

    always_comb begin
        skip = (int'(wlk_addr) == RC_ADDR) || (int'(wlk_addr) == FC_ADDR) ||
               ((int'(wlk_addr) >= SCR_BASE) && (int'(wlk_addr) < SCR_END)) ||
               (keep_bit && (int'(wlk_addr) >= KEEP_LO) && (int'(wlk_addr) <= KEEP_HI));
    end

    // Outputs
    always_comb begin
        nv_req    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (state)
            S_INIT: begin
                ram_we    = 1'b1;
                ram_addr  = RAM_AW'(FC_ADDR);
                ram_wdata = fail_cnt;
            end
            S_FETCH: begin
                nv_req = 1'b1;
                if (nv_vld) begin
                    ram_we    = 1'b1;
                    ram_addr  = RAM_AW'(SCR_BASE) + RAM_AW'(idx);
                    ram_wdata = nv_data;
                end
            end
            S_FAIL: begin
                ram_we    = 1'b1;
                ram_addr  = RAM_AW'(FC_ADDR);
                ram_wdata = fail_cnt + 8'd1;
            end
            S_CLEAR: begin
                ram_we   = !skip;
                ram_addr = wlk_addr;
            end
            S_RCODE: begin
                ram_we    = 1'b1;
                ram_addr  = RAM_AW'(RC_ADDR);
                ram_wdata = soft_q ? RC_SOFT : RC_OK;
            end
            default: ;
        endcase
    end

    assign nv_addr   = NV_AW'(NV_BASE) + NV_AW'(idx);
    assign cal_regs  = cal_q;
    assign ires_req  = (state == S_FAIL);
    assign boot_done = (state == S_DONE);
    assign cpu_run   = run_q;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && !nv_vld && !rst_event) |=> (nv_req && $stable(nv_addr)));

    p_ires_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ires_req |=> (!ires_req && !cpu_run));

    p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ires_req && boot_done));

    p_clear_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLEAR && ram_we) |->
            (int'(ram_addr) != RC_ADDR && int'(ram_addr) != FC_ADDR && ram_wdata == 8'h00));

    p_rcode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && int'(ram_addr) == RC_ADDR) |-> (ram_wdata == RC_OK || ram_wdata == RC_SOFT));

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !rst_event) |=> cpu_run);

    p_held_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> !cpu_run);

endmodule

// File: tb/bootcal_seq_bench.sv
`timescale 1ns/1ps
module bootcal_seq_bench;

    localparam int CAL_LEN = 16;
    localparam int CAL_N   = CAL_LEN - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_event = 1'b0;
    logic [1:0] rst_cause = 2'd0;
    logic sv_call = 1'b0;
    logic [7:0] sv_acc = 8'h00;
    logic keep_we = 1'b0;
    logic keep_d = 1'b0;
    logic nv_req;
    logic [7:0] nv_addr;
    logic nv_vld = 1'b0;
    logic [7:0] nv_data = 8'h00;
    logic ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [CAL_N*8-1:0] cal_regs;
    logic ires_req;
    logic cpu_run;
    logic boot_done;

    always #2.5 clk = ~clk;

    bootcal_seq u_bootcal_seq (
        .clk(clk), .rst_n(rst_n), .rst_event(rst_event), .rst_cause(rst_cause),
        .sv_call(sv_call), .sv_acc(sv_acc), .keep_we(keep_we), .keep_d(keep_d),
        .nv_req(nv_req), .nv_addr(nv_addr), .nv_vld(nv_vld), .nv_data(nv_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cal_regs(cal_regs), .ires_req(ires_req), .cpu_run(cpu_run), .boot_done(boot_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] nvmem [0:15];
    logic [7:0] ram [0:255];
    logic [CAL_N*8-1:0] exp_cal;
    int nv_lat = 0;
    int nv_accept = 0;
    int nv_bad = 0;
    int done_cnt = 0;
    int ires_cnt = 0;
    int wr_cnt = 0;
    bit fill_req = 1'b0;

    // Nonvolatile memory with variable latency
    always @(posedge clk) begin
        if (nv_req && nv_vld) begin
            nv_vld <= 1'b0;
            nv_lat <= (int'(nv_addr) * 3 + nv_accept) % 4;
            if (int'(nv_addr) != (nv_accept % CAL_LEN)) nv_bad <= nv_bad + 1;
            nv_accept <= nv_accept + 1;
        end else if (nv_req) begin
            if (nv_lat == 0) begin
                nv_vld  <= 1'b1;
                nv_data <= nvmem[nv_addr[3:0]];
            end else begin
                nv_lat <= nv_lat - 1;
            end
        end
    end

    // RAM model and event counters
    always @(posedge clk) begin
        if (fill_req) begin
            for (int a = 0; a < 256; a++) ram[a] <= 8'h5A;
        end else if (ram_we) begin
            ram[ram_addr] <= ram_wdata;
        end
        if (ram_we) wr_cnt <= wr_cnt + 1;
        if (boot_done) done_cnt <= done_cnt + 1;
        if (ires_req) ires_cnt <= ires_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic prep_nv(input int seed, input bit good);
        logic [15:0] sum;
        logic [15:0] word;
        sum = 16'h0000;
        for (int i = 0; i < CAL_N; i++) begin
            logic [7:0] b;
            b = 8'((seed * 37 + i * 11 + 3) & 'hFF) ^ 8'hC3;
            nvmem[i] = b;
            exp_cal[i*8 +: 8] = b;
            sum = sum + {8'h00, b};
        end
        word = 16'h0000 - (sum + 16'h00EB);
        if (!good) word = word + 16'h0001;
        nvmem[CAL_N]   = word[7:0];
        nvmem[CAL_N+1] = word[15:8];
    endtask

    task automatic fill_ram();
        @(negedge clk); fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
    endtask

    task automatic set_keep(input bit v);
        @(negedge clk); keep_we = 1'b1; keep_d = v;
        @(negedge clk); keep_we = 1'b0;
    endtask

    task automatic run_entry(input bit sv, input logic [1:0] cause, input logic [7:0] acc);
        int d0;
        int i0;
        d0 = done_cnt;
        i0 = ires_cnt;
        @(negedge clk);
        if (sv) begin sv_call = 1'b1; sv_acc = acc; end
        else    begin rst_event = 1'b1; rst_cause = cause; end
        @(negedge clk);
        sv_call = 1'b0;
        rst_event = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (done_cnt != d0 || ires_cnt != i0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_image(input bit good, input bit keep, input logic [7:0] rc,
                               input logic [7:0] fc, input string tag);
        int bad;
        bad = 0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            if (a == 'hF8)                     e = good ? rc : 8'h5A;
            else if (a == 'hFC)                e = fc;
            else if (a >= 'hE0 && a < 'hF0)    e = nvmem[a - 'hE0];
            else if (!good)                    e = 8'h5A;
            else if (keep && a >= 'hC0 && a <= 'hDF) e = 8'h5A;
            else                               e = 8'h00;
            if (ram[a] !== e) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] fc_exp;
        logic [CAL_N*8-1:0] cal_prev;
        int d0;
        int i0;
        int wr0;
        fc_exp = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cpu_run == 1'b0, "R11 held after power-up", int'(cpu_run), 0);
        chk(nv_req == 1'b0, "R2 no read while idle", int'(nv_req), 0);
        chk(ram_we == 1'b0, "R9 no RAM write while idle", int'(ram_we), 0);
        chk(ires_req == 1'b0 && boot_done == 1'b0, "R6 no pulses while idle",
            int'({ires_req, boot_done}), 0);

        // Sweep over reset cause, preserve flag and checksum verdict
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 2; k++) begin
                for (int p = 0; p < 2; p++) begin
                    bit keep_exp;
                    prep_nv(c * 4 + k * 2 + p, p[0]);
                    fill_ram();
                    set_keep(k[0]);
                    keep_exp = k[0] && (c == 2);
                    if (c != 3) fc_exp = 8'h00;
                    if (p == 0) fc_exp = fc_exp + 8'h01;
                    cal_prev = cal_regs;
                    d0 = done_cnt;
                    i0 = ires_cnt;
                    run_entry(1'b0, 2'(c), 8'h00);
                    chk((done_cnt - d0) == p && (ires_cnt - i0) == (1 - p),
                        $sformatf("R4 checksum verdict cause=%0d keep=%0d", c, k),
                        done_cnt - d0, p);
                    if (p == 1) begin
                        chk(cpu_run == 1'b1, "R11 cpu released", int'(cpu_run), 1);
                        chk(cal_regs == exp_cal, "R5 calibration loaded",
                            int'(cal_regs[31:0]), int'(exp_cal[31:0]));
                        chk(ram[8'hF8] == 8'h00, "R10 hardware return code",
                            int'(ram[8'hF8]), 0);
                    end else begin
                        chk(ires_cnt - i0 == 1, "R6 single reset request", ires_cnt - i0, 1);
                        chk(cpu_run == 1'b0, "R6 cpu stays held", int'(cpu_run), 0);
                        chk(cal_regs == cal_prev, "R5 calibration unchanged on fail",
                            int'(cal_regs[31:0]), int'(cal_prev[31:0]));
                    end
                    chk(ram[8'hFC] == fc_exp, $sformatf("R7 fail count cause=%0d", c),
                        int'(ram[8'hFC]), int'(fc_exp));
                    check_image(p[0], keep_exp, 8'h00, fc_exp,
                        $sformatf("R9 RAM image (R8 keep=%0d, R3 scratch) cause=%0d", keep_exp, c));
                    chk(nv_bad == 0, "R2 read address order", nv_bad, 0);
                end
            end
        end

        // Supervisory calls
        prep_nv(40, 1'b1);
        fill_ram();
        set_keep(1'b1);
        wr0 = wr_cnt;
        @(negedge clk); sv_call = 1'b1; sv_acc = 8'h05;
        @(negedge clk); sv_call = 1'b0;
        repeat (40) @(negedge clk);
        chk(wr_cnt == wr0, "R1 nonzero accumulator ignored (writes)", wr_cnt - wr0, 0);
        chk(cpu_run == 1'b1, "R1 nonzero accumulator ignored (run)", int'(cpu_run), 1);

        d0 = done_cnt;
        run_entry(1'b1, 2'd0, 8'h00);
        chk(done_cnt - d0 == 1, "R1 zero accumulator runs sequence", done_cnt - d0, 1);
        chk(ram[8'hF8] == 8'h02, "R10 software return code", int'(ram[8'hF8]), 2);
        chk(ram[8'hFC] == fc_exp, "R7 fail count kept on call", int'(ram[8'hFC]), int'(fc_exp));
        check_image(1'b1, 1'b1, 8'h02, fc_exp, "R8 preserve flag kept over call (R9 image)");
        chk(cal_regs == exp_cal, "R5 calibration after call",
            int'(cal_regs[31:0]), int'(exp_cal[31:0]));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule